// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is an SPI master that moves 8-bit frames in mode 0 (SCK idles low, MISO sampled on the rising edge, MOSI updated on the falling edge), most significant bit first. The transmit side has two stages. A one-byte holding register takes the host's writes, and a shift register drives MOSI. When the controller is idle, a written byte skips the holding stage and enters the shifter on the same clock edge. A byte written during a frame waits in the holding register. It moves into the shifter on the final falling edge of the current frame, so the next frame follows with no idle bit and chip select stays asserted.

The host side is a set of single-cycle strobes. One strobe writes a transmit byte. One strobe reads (consumes) the received byte. One strobe clears the sticky error flags. Three status flags report state: transmit-empty, receive-full and busy. The serial clock period is 2×(DIV+1) system clocks. DIV is captured when an idle controller accepts a byte and is held for the rest of the transfer.

Top module: `spi_db_master`

## Requirements
- R1: After reset: txe=1, rxne=0, busy=0, csN=1, sck=0, ovr=0, wcol=0.
- R2: A write accepted while idle loads the shifter on that same clock edge. csN goes low and mosi shows bit 7 of the byte right after that edge. The first rising SCK edge comes H=DIV+1 system clocks later.
- R3: Mode 0, MSB first. sck is low whenever csN is high. mosi changes only when a byte loads or on a falling SCK edge. miso is captured on rising SCK edges.
- R4: The SCK high and low phases each last H system clocks. DIV is taken from divCfg on the idle write edge, and changing divCfg later in the transfer has no effect until the next idle start.
- R5: A byte written during a frame is held and loaded at that frame's eighth falling edge. The next rising edge follows H clocks later, with csN held low between the two frames.
- R6: txe falls on the edge that accepts a write. After any holding-to-shift or direct load, txe rises exactly 2H clocks (one bit time) after the load edge.
- R7: rxne rises on the eighth rising SCK edge of a frame (15H clocks after an idle load), and rxData then holds the full received byte.
- R8: A pulse on rxRdEn clears rxne. If a new byte completes on the same edge, rxne stays set.
- R9: If a byte completes while rxne is already set and no read happens on that edge, rxData is overwritten and ovr is set. ovr clears on a statRdEn pulse.
- R10: A write while txe=0 is ignored: the frames sent are unchanged and wcol is set. wcol clears on a statRdEn pulse.
- R11: busy equals !csN. When nothing is pending, csN rises H clocks after the last falling edge (17H clocks after an idle load).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divCfg | input | 8 | Clock divider value DIV |
| txWrEn | input | 1 | Write strobe for a transmit byte |
| txWrData | input | 8 | Transmit byte |
| rxRdEn | input | 1 | Read strobe; consumes rxData |
| statRdEn | input | 1 | Status read strobe; clears ovr and wcol |
| rxData | output | 8 | Last received byte |
| txe | output | 1 | Transmit holding stage can accept a byte |
| rxne | output | 1 | Unread received byte present |
| busy | output | 1 | Transfer in progress |
| ovr | output | 1 | Sticky receive overrun |
| wcol | output | 1 | Sticky write collision |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| csN | output | 1 | Active-low chip select |
| miso | input | 1 | Serial data in |

## Verification
Every result is due a fixed number of system clocks after the write edge E0, with H=DIV+1:
- csN, busy and mosi change at E0.
- The first rising SCK edge is at E0+H.
- txe rises at E0+2H.
- rxne rises at E0+15H.
- csN is released at E0+17H.
- In back-to-back frames each of these times shifts by 16H.

The bench counts clock edges from E0 and samples 1 ns after each edge. It checks a flag one clock before its due edge (still old value) and at the due edge (new value), so an early or late flag fails. A bus-slave model in the bench checks the serial data: it returns a known byte per frame and logs what it received on MOSI.

// File: rtl/spi_db_pkg.sv
package spi_db_pkg;

  // Control-to-datapath strobes, all single-cycle.
  typedef struct packed {
    logic ldDirect;  // host byte straight into the shifter (idle start)
    logic ldHold;    // holding register into the shifter
    logic holdWr;    // host byte into the holding register
    logic shiftOut;  // advance the transmit shifter (falling edge)
    logic sampleIn;  // capture miso (rising edge)
    logic commitRx;  // parallel copy of the completed byte
  } spiStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TRAIL = 2'd2
  } spiState_t;

endpackage

// File: rtl/spi_db_dpath.sv
module spi_db_dpath
  import spi_db_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobe_t        stb,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              miso,
  output logic              mosi,
  output logic              holdFull,
  output logic [DATA_W-1:0] rxData
);

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxNext;

  assign rxNext = {rxShift[DATA_W-2:0], miso};
  assign mosi   = txShift[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else if (stb.holdWr) begin
      holdReg  <= txWrData;
      holdFull <= 1'b1;
    end else if (stb.ldHold) begin
      holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (stb.ldDirect) begin
      txShift <= txWrData;
    end else if (stb.ldHold) begin
      txShift <= holdReg;
    end else if (stb.shiftOut) begin
      txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      rxData  <= '0;
    end else if (stb.sampleIn) begin
      rxShift <= rxNext;
      if (stb.commitRx) rxData <= rxNext;
    end
  end

  // R5: the holding stage is only written while empty
  assert_hold_empty_on_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.holdWr |-> !holdFull);

  // R3: mosi moves only on a load or a shift strobe
  assert_mosi_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.ldDirect || stb.ldHold || stb.shiftOut) |=> $stable(mosi));

endmodule

// File: rtl/spi_db_ctrl.sv
module spi_db_ctrl
  import spi_db_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divCfg,
  input  logic             txWrEn,
  input  logic             rxRdEn,
  input  logic             statRdEn,
  input  logic             holdFull,
  output spiStrobe_t       stb,
  output logic             sck,
  output logic             csN,
  output logic             busy,
  output logic             txe,
  output logic             rxne,
  output logic             ovr,
  output logic             wcol
);

  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  spiState_t        state;
  logic [DIV_W-1:0] divReg;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             txeWait;
  logic             txeHalf;

  logic tick, accept, idleLoad, rise, fall, lastFall, trailEnd, chain;

  assign tick     = (state != ST_IDLE) && (divCnt == divReg);
  assign accept   = txWrEn && txe;
  assign idleLoad = accept && (state == ST_IDLE);
  assign rise     = tick && (state == ST_SHIFT) && !sck;
  assign fall     = tick && (state == ST_SHIFT) && sck;
  assign lastFall = fall && (bitCnt == LAST_BIT);
  assign trailEnd = tick && (state == ST_TRAIL);
  assign chain    = (lastFall || trailEnd) && holdFull;

  always_comb begin
    stb          = '0;
    stb.ldDirect = idleLoad;
    stb.holdWr   = accept && (state != ST_IDLE);
    stb.ldHold   = chain;
    stb.shiftOut = fall && !lastFall;
    stb.sampleIn = rise;
    stb.commitRx = rise && (bitCnt == LAST_BIT);
  end

  assign csN  = (state == ST_IDLE);
  assign busy = (state != ST_IDLE);

  // Sequencing: state, divider, bit counter, serial clock.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divReg <= '0;
      divCnt <= '0;
      bitCnt <= '0;
      sck    <= 1'b0;
    end else begin
      if (idleLoad) begin
        divReg <= divCfg;
        divCnt <= '0;
      end else if (state != ST_IDLE) begin
        divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      end

      if (rise) sck <= 1'b1;
      if (fall) sck <= 1'b0;

      if (idleLoad || lastFall) bitCnt <= '0;
      else if (fall)            bitCnt <= bitCnt + CNT_W'(1);

      case (state)
        ST_IDLE:  if (idleLoad) state <= ST_SHIFT;
        ST_SHIFT: if (lastFall && !holdFull) state <= ST_TRAIL;
        ST_TRAIL: if (trailEnd) begin
                    if (holdFull)    state <= ST_SHIFT;
                    else if (accept) state <= ST_TRAIL;
                    else             state <= ST_IDLE;
                  end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // Transmit-empty: drops on acceptance, returns one bit time after a load.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txe     <= 1'b1;
      txeWait <= 1'b0;
      txeHalf <= 1'b0;
    end else if (idleLoad || chain) begin
      txe     <= 1'b0;
      txeWait <= 1'b1;
      txeHalf <= 1'b0;
    end else begin
      if (accept) txe <= 1'b0;
      if (tick && txeWait) begin
        if (txeHalf) begin
          txe     <= 1'b1;
          txeWait <= 1'b0;
        end else begin
          txeHalf <= 1'b1;
        end
      end
    end
  end

  // Receive and error flags; a set on the same edge wins over a clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxne <= 1'b0;
      ovr  <= 1'b0;
      wcol <= 1'b0;
    end else begin
      if (stb.commitRx)  rxne <= 1'b1;
      else if (rxRdEn)   rxne <= 1'b0;

      if (stb.commitRx && rxne && !rxRdEn) ovr <= 1'b1;
      else if (statRdEn)                   ovr <= 1'b0;

      if (txWrEn && !txe)  wcol <= 1'b1;
      else if (statRdEn)   wcol <= 1'b0;
    end
  end

  // R3: clock idles low while deselected
  assert_sck_idle_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  // R10: a refused write raises the collision flag
  assert_wcol_on_refused_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (txWrEn && !txe) |=> wcol);

  // R8: a read without a completing byte leaves rxne low
  assert_read_clears_rxne_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxRdEn && !stb.commitRx) |=> !rxne);

  // R9: completion onto an unread byte flags overrun
  assert_overrun_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commitRx && rxne && !rxRdEn) |=> ovr);

  // R6: an accepted write empties the transmit flag
  assert_txe_drops_R6: assert property (@(posedge clk) disable iff (!rstN)
    (txWrEn && txe) |=> !txe);

  // R11: no byte is stranded once deselected
  assert_idle_nothing_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !holdFull);

endmodule

// File: rtl/spi_db_master.sv
module spi_db_master
  import spi_db_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divCfg,
  input  logic              txWrEn,
  input  logic [DATA_W-1:0] txWrData,
  input  logic              rxRdEn,
  input  logic              statRdEn,
  output logic [DATA_W-1:0] rxData,
  output logic              txe,
  output logic              rxne,
  output logic              busy,
  output logic              ovr,
  output logic              wcol,
  output logic              sck,
  output logic              mosi,
  output logic              csN,
  input  logic              miso
);

  spiStrobe_t stb;
  logic       holdFull;

  spi_db_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .divCfg(divCfg), .txWrEn(txWrEn),
    .rxRdEn(rxRdEn), .statRdEn(statRdEn), .holdFull(holdFull),
    .stb(stb), .sck(sck), .csN(csN), .busy(busy), .txe(txe),
    .rxne(rxne), .ovr(ovr), .wcol(wcol)
  );

  spi_db_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .stb(stb), .txWrData(txWrData),
    .miso(miso), .mosi(mosi), .holdFull(holdFull), .rxData(rxData)
  );

endmodule

// File: tb/sim_spi_db_master.sv
module sim_spi_db_master;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divCfg = 8'd1;
  logic       txWrEn = 1'b0;
  logic [7:0] txWrData = 8'h00;
  logic       rxRdEn = 1'b0;
  logic       statRdEn = 1'b0;
  logic [7:0] rxData;
  logic       txe, rxne, busy, ovr, wcol, sck, mosi, csN, miso;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_db_master u0 (
    .clk(clk), .rstN(rstN), .divCfg(divCfg), .txWrEn(txWrEn),
    .txWrData(txWrData), .rxRdEn(rxRdEn), .statRdEn(statRdEn),
    .rxData(rxData), .txe(txe), .rxne(rxne), .busy(busy), .ovr(ovr),
    .wcol(wcol), .sck(sck), .mosi(mosi), .csN(csN), .miso(miso)
  );

  // Bus-slave model: sends slvSeq bytes MSB first, logs bytes seen on mosi.
  logic [7:0] slvSeq [4];
  logic [1:0] slvIdx = 2'd0;
  logic [2:0] slvBits = 3'd0;
  logic [7:0] slvIn = 8'h00;
  int         rxBits = 0;
  logic [7:0] gotLog [16];
  int         gotCnt = 0;

  assign miso = slvSeq[slvIdx][3'd7 - slvBits];

  always @(negedge sck or posedge csN) begin
    if (csN) begin
      slvBits = 3'd0;
      slvIdx  = 2'd0;
    end else if (slvBits == 3'd7) begin
      slvBits = 3'd0;
      slvIdx  = slvIdx + 2'd1;
    end else begin
      slvBits = slvBits + 3'd1;
    end
  end

  always @(posedge sck or posedge csN) begin
    if (csN) begin
      rxBits = 0;
    end else begin
      slvIn  = {slvIn[6:0], mosi};
      rxBits = rxBits + 1;
      if (rxBits == 8) begin
        if (gotCnt < 16) gotLog[gotCnt] = slvIn;
        gotCnt = gotCnt + 1;
        rxBits = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wrByte(input logic [7:0] d);
    @(negedge clk);
    txWrEn = 1'b1;
    txWrData = d;
    @(posedge clk);
    #1;
    txWrEn = 1'b0;
  endtask

  task automatic rdRx();
    @(negedge clk);
    rxRdEn = 1'b1;
    @(posedge clk);
    #1;
    rxRdEn = 1'b0;
  endtask

  task automatic rdStat();
    @(negedge clk);
    statRdEn = 1'b1;
    @(posedge clk);
    #1;
    statRdEn = 1'b0;
  endtask

  task automatic tReset();
    chk("R1 txe", txe, 1);
    chk("R1 rxne", rxne, 0);
    chk("R1 busy", busy, 0);
    chk("R1 csN", csN, 1);
    chk("R1 sck", sck, 0);
    chk("R1 ovr/wcol", {ovr, wcol}, 0);
  endtask

  // DIV=1 so H=2
  task automatic tSingle();
    int base = gotCnt;
    slvSeq[0] = 8'h3C;
    wrByte(8'hA5);                  // E0
    chk("R2 csN low at load", csN, 0);
    chk("R11 busy at load", busy, 1);
    chk("R2 mosi msb at load", mosi, 1);
    chk("R6 txe drops", txe, 0);
    step(1);  chk("R2 sck low at E0+1", sck, 0);
    step(1);  chk("R2 first rise at E0+H", sck, 1);
    step(1);  chk("R6 txe still low at E0+3", txe, 0);
    step(1);  chk("R6 txe high at E0+2H", txe, 1);
    step(25); chk("R7 rxne low at E0+29", rxne, 0);
    step(1);  chk("R7 rxne at E0+15H", rxne, 1);
    chk("R7 rxData", rxData, 8'h3C);
    step(3);  chk("R11 csN held at E0+33", csN, 0);
    step(1);  chk("R11 csN released at E0+17H", csN, 1);
    chk("R11 busy clear", busy, 0);
    chk("R3 slave got A5", (gotCnt - base == 1) ? gotLog[base] : 8'hxx, 8'hA5);
    rdRx();
    chk("R8 read clears rxne", rxne, 0);
  endtask

  task automatic tBackToBack();
    int base = gotCnt;
    slvSeq[0] = 8'hC3;
    slvSeq[1] = 8'h5A;
    wrByte(8'h81);                  // E0
    step(4);  chk("R6 txe up before second write", txe, 1);
    wrByte(8'h7E);                  // E0+5
    chk("R6 txe drops on held write", txe, 0);
    step(29);                       // E0+34
    chk("R5 next frame rises without gap", sck, 1);
    chk("R5 csN stays low", csN, 0);
    chk("R7 first byte received", rxData, 8'hC3);
    step(1);  chk("R6 txe low at chain+3", txe, 0);
    step(1);  chk("R6 txe high at chain+2H", txe, 1);
    step(25); chk("R9 ovr clear before second byte", ovr, 0);
    step(1);  chk("R9 ovr set on unread overwrite", ovr, 1);
    chk("R9 rxData overwritten", rxData, 8'h5A);
    step(3);  chk("R11 csN low before release", csN, 0);
    step(1);  chk("R11 csN released after two frames", csN, 1);
    chk("R5 two frames seen", gotCnt - base, 2);
    chk("R5 frame1 byte", gotLog[base], 8'h81);
    chk("R5 frame2 byte", gotLog[base+1], 8'h7E);
    rdStat();
    chk("R9 status read clears ovr", ovr, 0);
    chk("R8 rxne survives status read", rxne, 1);
    rdRx();
    chk("R8 read clears rxne", rxne, 0);
  endtask

  task automatic tCollision();
    int base = gotCnt;
    slvSeq[0] = 8'h00;
    wrByte(8'h55);                  // E0
    wrByte(8'hAA);                  // E0+1, txe low
    chk("R10 wcol set", wcol, 1);
    step(33);                       // E0+34
    chk("R10 single frame only, csN", csN, 1);
    chk("R10 busy clear", busy, 0);
    chk("R10 frames sent", gotCnt - base, 1);
    chk("R10 byte sent", gotLog[base], 8'h55);
    rdStat();
    chk("R10 status read clears wcol", wcol, 0);
    rdRx();
  endtask

  // DIV=3 so H=4; divCfg changed mid-frame must not matter
  task automatic tDivider();
    slvSeq[0] = 8'hF0;
    divCfg = 8'd3;
    wrByte(8'h0F);                  // E0
    step(3);  chk("R4 sck low at E0+3", sck, 0);
    step(1);  chk("R4 rise at E0+H", sck, 1);
    divCfg = 8'd0;
    step(3);  chk("R4 still high at E0+7", sck, 1);
    step(1);  chk("R4 fall at E0+2H", sck, 0);
    step(4);  chk("R4 rise at E0+3H despite divCfg change", sck, 1);
    step(55); chk("R11 csN low at E0+67", csN, 0);
    step(1);  chk("R11 csN released at E0+68", csN, 1);
    chk("R7 rxData at DIV=3", rxData, 8'hF0);
    divCfg = 8'd1;
    rdRx();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    step(1);
    tReset();
    tSingle();
    tBackToBack();
    tCollision();
    tDivider();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule